// File: doc/BRIEF.md
# Variable-Length Serial Peripheral Master

The block is the master side of a four-wire serial peripheral link. It exchanges between 1 and `DATA_W` bits with one slave per transfer. A host reaches it through a single shared bidirectional data bus and a few control strobes.

A write strobe captures the bus word into a transmit holding register. A read strobe makes the block drive its receive register onto the same bus; at all other times the block releases the bus. A start strobe launches a transfer that uses the word currently held. The clock polarity and clock phase inputs pick one of the four standard serial modes. The serial clock runs at half the system clock for the whole transfer. Busy, done and an active-low slave select show where the exchange stands.

The payload always sits at the most significant end of the bus word. Bits go out MSB first. Received bits come back left-justified, with zeros below them.

Top module: `spi_len_master`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `clk` edge) clears the transmit holding word, the receive word and any transfer in progress. Afterwards `busy`=0, `done`=0 and `ss_n`=1, a readback gives 0, and a transfer started without a new write sends only zeros on `mosi`.
- R2: During a transfer, `sck` inverts on every system clock cycle. While idle, `sck` equals `cpol`.
- R3: At each rising edge where `we` is high, the bus value is copied into the transmit holding word, also while a transfer is running. A transfer already under way keeps shifting the word it started with.
- R4: While `oe` is high, the block drives the receive word onto `data`. Otherwise it leaves `data` undriven, so that the host can write.
- R5: With `cpha`=0, `mosi` holds bit k before the k-th leading `sck` edge, and `miso` is captured on leading edges. With `cpha`=1, `mosi` changes on leading edges and `miso` is captured on trailing edges. The leading edge is the one that moves `sck` away from `cpol`.
- R6: A transfer of N bits keeps `busy` high for exactly 2N clock cycles. It sends bits `DATA_W-1` down to `DATA_W-N` of the held word on `mosi`, in that order, and `mosi` is 0 while idle.
- R7: When a transfer ends, the receive word holds the first captured bit at bit `DATA_W-1` and the N-th at bit `DATA_W-N`, and all lower bits are 0.
- R8: `done` rises in the cycle `busy` falls. It stays high until the next transfer starts or a reset occurs, and it is never high together with `busy`.
- R9: `ss_n` is low exactly while `busy` is high.
- R10: Raising `en` while `busy` is high has no effect on the transfer, and no transfer is queued by it.
- R11: A `xfer_len` of 0, or one greater than `DATA_W`, gives a transfer of `DATA_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Start a transfer when idle |
| we | input | 1 | Load the bus word into the transmit holding register |
| oe | input | 1 | Drive the receive word onto the bus |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| xfer_len | input | LEN_W | Number of bits to exchange (clamped) |
| data | inout | DATA_W | Shared host data bus |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Slave select, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |

## Verification
The bound checker watches, on every clock, that the serial clock flips each cycle of a transfer and that select tracks busy. It also checks that done and busy exclude each other, that done appears as busy falls and holds until the next start, and that no transfer runs longer than 2·`DATA_W` cycles. The values carried are left to the bench. Its model predicts `mosi`, the idle clock level, the bus readback and the left-justified receive word in every cycle. Its scenarios alone show the four modes, length clamping, loads during a transfer, ignored starts and a reset part-way through a transfer.

// File: rtl/spi_len_pkg.sv
package spi_len_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Per-cycle strobes from the sequencer to the data path
    typedef struct packed {
        logic start;   // transfer accepted this cycle
        logic shift;   // advance the outgoing word
        logic sample;  // capture miso
        logic finish;  // last half period ends
    } seq_tick_t;

endpackage

// File: rtl/spi_len_seq.sv
module spi_len_seq
    import spi_len_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [LEN_W-1:0] len_eff,
    output seq_tick_t        tick,
    output logic [LEN_W-1:0] len_q,
    output logic             sck,
    output logic             ss_n,
    output logic             busy,
    output logic             done
);
    localparam int CNT_W = LEN_W + 1;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] half;
        logic [CNT_W-1:0] last;
        logic [LEN_W-1:0] len;
        logic             sck;
        logic             ss_n;
        logic             done;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = '0;
        unique case (s_q.state)
            SEQ_IDLE: begin
                s_d.sck = cpol;
                if (en) begin
                    tick.start = 1'b1;
                    s_d.state  = SEQ_RUN;
                    s_d.half   = '0;
                    s_d.last   = {len_eff, 1'b0} - CNT_W'(1);
                    s_d.len    = len_eff;
                    s_d.sck    = cpol ^ cpha;
                    s_d.ss_n   = 1'b0;
                    s_d.done   = 1'b0;
                end
            end
            SEQ_RUN: begin
                // even half periods end on a capture edge in every mode
                tick.sample = ~s_q.half[0];
                if (s_q.half == s_q.last) begin
                    tick.finish = 1'b1;
                    s_d.state   = SEQ_IDLE;
                    s_d.ss_n    = 1'b1;
                    s_d.done    = 1'b1;
                    s_d.sck     = cpol;
                end else begin
                    tick.shift = s_q.half[0];
                    s_d.half   = s_q.half + CNT_W'(1);
                    s_d.sck    = ~s_q.sck;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.state <= SEQ_IDLE;
            s_q.half  <= '0;
            s_q.last  <= '0;
            s_q.len   <= '0;
            s_q.sck   <= 1'b0;
            s_q.ss_n  <= 1'b1;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = (s_q.state == SEQ_RUN);
    assign sck   = busy ? s_q.sck : cpol;
    assign ss_n  = s_q.ss_n;
    assign done  = s_q.done;
    assign len_q = s_q.len;

endmodule

// File: rtl/spi_len_dp.sv
module spi_len_dp
    import spi_len_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_data,
    input  seq_tick_t         tick,
    input  logic [LEN_W-1:0]  len_q,
    input  logic              busy,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    typedef struct packed {
        logic [DATA_W-1:0] tx_hold;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] rx_hold;
    } dp_regs_t;

    dp_regs_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (we) begin
            d_d.tx_hold = wr_data;
        end
        if (tick.start) begin
            d_d.tx_sh = d_q.tx_hold;
            d_d.rx_sh = '0;
        end
        if (tick.sample) begin
            d_d.rx_sh = {d_q.rx_sh[DATA_W-2:0], miso};
        end
        if (tick.shift) begin
            d_d.tx_sh = {d_q.tx_sh[DATA_W-2:0], 1'b0};
        end
        if (tick.finish) begin
            d_d.rx_hold = d_q.rx_sh << (DATA_W - int'(len_q));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign mosi    = busy & d_q.tx_sh[DATA_W-1];
    assign rx_word = d_q.rx_hold;

endmodule

// File: rtl/spi_len_master.sv
module spi_len_master
    import spi_len_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic              oe,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [LEN_W-1:0]  xfer_len,
    inout  wire  [DATA_W-1:0] data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n,
    output logic              busy,
    output logic              done
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

    logic [LEN_W-1:0]  len_eff;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] rx_word;
    seq_tick_t         tick;

    assign len_eff = ((xfer_len == '0) || (xfer_len > FULL_LEN)) ? FULL_LEN : xfer_len;

    spi_len_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .cpol    (cpol),
        .cpha    (cpha),
        .len_eff (len_eff),
        .tick    (tick),
        .len_q   (len_q),
        .sck     (sck),
        .ss_n    (ss_n),
        .busy    (busy),
        .done    (done)
    );

    spi_len_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .wr_data (data),
        .tick    (tick),
        .len_q   (len_q),
        .busy    (busy),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_word)
    );

    assign data = oe ? rx_word : 'z;

endmodule

// File: rtl/spi_len_master_chk.sv
module spi_len_master_chk #(
    parameter int DATA_W = 16
) (
    input logic clk,
    input logic rst,
    input logic sck,
    input logic ss_n,
    input logic busy,
    input logic done
);
    localparam int MAX_RUN = 2 * DATA_W;

    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_len <= 0;
        end else begin
            run_len <= run_len + 1;
        end
    end

    assert_sck_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (sck != $past(sck)));

    assert_run_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < MAX_RUN));

    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_done_on_end_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(busy)) |-> done);

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(done) && !busy) |-> done);

    assert_select_busy_R9: assert property (@(posedge clk) disable iff (rst)
        ss_n == !busy);

endmodule

bind spi_len_master spi_len_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .sck  (sck),
    .ss_n (ss_n),
    .busy (busy),
    .done (done)
);

// File: tb/spi_len_master_tb.sv
`timescale 1ns/1ps
module spi_len_master_tb;
    localparam int W  = 16;
    localparam int LW = $clog2(W + 1);

    logic clk = 1'b0;
    logic rst, en, we, oe, cpol, cpha, miso;
    logic [LW-1:0] xfer_len;
    logic drv_en;
    logic [W-1:0] drv_val;
    wire  [W-1:0] data_bus;
    logic sck, mosi, ss_n, busy, done;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    bit       m_busy, m_done, m_sck;
    int       m_half, m_len, m_bit;
    logic [W-1:0] m_txbuf, m_word, m_rxbuf, slave_word;
    bit       m_rx[$];

    always #4 clk = ~clk;

    assign data_bus = drv_en ? drv_val : 'z;

    spi_len_master #(.DATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .we(we), .oe(oe),
        .cpol(cpol), .cpha(cpha), .xfer_len(xfer_len), .data(data_bus),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
        end
    endtask

    // behavioural model, updated on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_txbuf = '0; m_rxbuf = '0;
            m_half = 0; m_bit = 0; m_rx.delete();
        end else begin
            if (m_busy) begin
                if (m_half % 2 == 0) m_rx.push_back(miso);
                if (m_half == 2 * m_len - 1) begin
                    m_busy = 0;
                    m_done = 1;
                    m_rxbuf = '0;
                    foreach (m_rx[i]) m_rxbuf[W-1-i] = m_rx[i];
                end else begin
                    if (m_half % 2 == 1) m_bit++;
                    m_half++;
                    m_sck = !m_sck;
                end
            end else if (en) begin
                m_busy = 1; m_done = 0; m_half = 0; m_bit = 0;
                m_len  = (xfer_len == 0 || int'(xfer_len) > W) ? W : int'(xfer_len);
                m_word = m_txbuf;
                m_sck  = cpol ^ cpha;
                m_rx.delete();
            end
            if (we) m_txbuf = data_bus;
        end
    end

    // per-cycle comparison, away from the edges; also drives the slave bit
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            check(busy === m_busy, "R8 busy", W'(busy), W'(m_busy));
            check(done === m_done, "R8 done", W'(done), W'(m_done));
            check(ss_n === !m_busy, "R9 ss_n", W'(ss_n), W'(!m_busy));
            check(sck === (m_busy ? m_sck : cpol), "R2/R5 sck", W'(sck),
                  W'(m_busy ? m_sck : cpol));
            check(mosi === (m_busy ? m_word[W-1-m_bit] : 1'b0), "R6/R3 mosi",
                  W'(mosi), W'(m_busy ? m_word[W-1-m_bit] : 1'b0));
            if (oe && !drv_en)
                check(data_bus === m_rxbuf, "R4/R7 bus readback", data_bus, m_rxbuf);
        end
        if (m_busy && m_half % 2 == 0 && m_rx.size() < W)
            miso = slave_word[W-1-m_rx.size()];
    end

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic write_tx(input logic [W-1:0] v);
        @(negedge clk); drv_en = 1; drv_val = v; we = 1;
        @(negedge clk); we = 0; drv_en = 0;
    endtask

    task automatic read_rx(output logic [W-1:0] v);
        @(negedge clk); oe = 1; #1 v = data_bus;
        @(negedge clk); oe = 0;
    endtask

    task automatic run_xfer(input int len, input bit pol, input bit pha,
                            input logic [W-1:0] sw, input int poke_at,
                            input logic [W-1:0] poke_val,
                            output int cycles, output int ones);
        @(negedge clk);
        cpol = pol; cpha = pha; xfer_len = LW'(len); slave_word = sw; en = 1;
        @(negedge clk); en = 0;
        cycles = 0; ones = 0;
        while (busy) begin
            cycles++;
            #1 if (mosi) ones++;
            if (cycles == poke_at) begin
                en = 1; drv_en = 1; drv_val = poke_val; we = 1;
            end else begin
                en = 0; we = 0; drv_en = 0;
            end
            @(negedge clk);
            if (cycles > 4 * W) break;
        end
        en = 0; we = 0; drv_en = 0;
    endtask

    function automatic logic [W-1:0] top_bits(input logic [W-1:0] v, input int n);
        return (v >> (W - n)) << (W - n);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R8: run did not end, actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] rv;
        int cyc, ones;
        rst = 1; en = 0; we = 0; oe = 0; cpol = 0; cpha = 0; miso = 0;
        xfer_len = '0; drv_en = 0; drv_val = '0; slave_word = '0;
        do_reset();

        // R1: reset state
        @(negedge clk); #1;
        check(busy === 0 && done === 0 && ss_n === 1, "R1 reset flags",
              W'({busy, done, ss_n}), W'(3'b001));
        read_rx(rv);
        check(rv === '0, "R1 reset rx", rv, '0);

        // mode 0, full length
        write_tx(16'hA5C3);
        run_xfer(16, 0, 0, 16'h3C5A, 0, '0, cyc, ones);
        check(cyc == 32, "R6 busy length 16", W'(cyc), W'(32));
        check(done === 1, "R8 done after end", W'(done), 1);
        read_rx(rv);
        check(rv === 16'h3C5A, "R7 rx mode0", rv, 16'h3C5A);

        // R8: done holds while idle
        repeat (5) @(negedge clk);
        #1 check(done === 1, "R8 done held", W'(done), 1);

        // R5 mode 1, R3 held word reused
        run_xfer(8, 0, 1, 16'hB7E1, 0, '0, cyc, ones);
        check(cyc == 16, "R6 busy length 8", W'(cyc), W'(16));
        read_rx(rv);
        check(rv === 16'hB700, "R7 rx mode1", rv, 16'hB700);

        // R5 mode 2, short length, R7 zeros below
        write_tx(16'h6F00);
        run_xfer(5, 1, 0, 16'hFFFF, 0, '0, cyc, ones);
        read_rx(rv);
        check(rv === 16'hF800, "R7 rx mode2 len5", rv, 16'hF800);

        // R5 mode 3, single bit
        run_xfer(1, 1, 1, 16'h8000, 0, '0, cyc, ones);
        check(cyc == 2, "R6 busy length 1", W'(cyc), W'(2));
        read_rx(rv);
        check(rv === 16'h8000, "R7 rx mode3 len1", rv, 16'h8000);

        // R11 clamping
        run_xfer(0, 0, 0, 16'h1234, 0, '0, cyc, ones);
        check(cyc == 32, "R11 len 0 clamps", W'(cyc), W'(32));
        run_xfer(20, 0, 1, 16'h4321, 0, '0, cyc, ones);
        check(cyc == 32, "R11 len 20 clamps", W'(cyc), W'(32));
        read_rx(rv);
        check(rv === 16'h4321, "R11 rx full word", rv, 16'h4321);

        // R10 start during busy ignored; R3 load during busy
        write_tx(16'hFF00);
        run_xfer(4, 0, 0, 16'hA000, 3, 16'h00FF, cyc, ones);
        check(cyc == 8, "R10 length unchanged", W'(cyc), W'(8));
        check(ones == 8, "R3 old word keeps shifting", W'(ones), W'(8));
        repeat (2) @(negedge clk);
        #1 check(busy === 0, "R10 no queued transfer", W'(busy), 0);
        run_xfer(8, 0, 0, 16'h0000, 0, '0, cyc, ones);
        check(ones == 0, "R3 word loaded during busy", W'(ones), W'(0));
        check(done === 1, "R8 done again", W'(done), 1);

        // R1 reset in mid transfer
        write_tx(16'hFFFF);
        @(negedge clk); xfer_len = LW'(16); slave_word = 16'hFFFF; en = 1;
        @(negedge clk); en = 0;
        repeat (5) @(negedge clk);
        rst = 1; @(negedge clk); rst = 0;
        #1 check(busy === 0 && ss_n === 1 && done === 0, "R1 reset mid transfer",
                 W'({busy, ss_n, done}), W'(3'b010));
        read_rx(rv);
        check(rv === '0, "R1 rx cleared", rv, '0);
        run_xfer(16, 0, 0, 16'h0F0F, 0, '0, cyc, ones);
        check(ones == 0, "R1 tx cleared", W'(ones), W'(0));

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule